// File: doc/BRIEF.md
# Configuration Fuse and Lock Readback Controller

This block sits beside a small CPU core. It lets software read the nonvolatile configuration (the fuse low byte and the two lock bits) through the ordinary program-memory load path. Software opens a short readback window by writing a control register with two enable bits set together. While that window is open, a load whose 16-bit pointer holds 0x0000 or 0x0001 returns configuration data instead of the flash byte. The window closes by itself. It closes when a load uses it, when a store arrives, when the shorter of the load and store windows runs out, or when an EEPROM write is in progress.

The control register layout belongs to this block. Bit 3 is the read-configuration enable and bit 0 is the self-program enable. All other bits read as 0. Load results are registered: they appear on `loadData` in the cycle after the load strobe and hold until the next load.

Top module: `cfg_readback`

## Requirements
- R1: A register write of exactly 0x09 (bit 3 and bit 0 set, every other bit clear) while `eeBusy` is low arms readback, and `ctrlReg` then reads 0x09. Any other written value leaves both bits clear, and `ctrlReg` reads 0x00.
- R2: A load sampled at any of the first LOAD_WIN clock edges after the arming edge (default 3) returns configuration data.
- R3: While armed, pointer 0x0000 returns `fuseLow`. Pointer 0x0001 returns 0xFC OR'd with `lockBits`, so the second lock bit lands in bit 1, the first in bit 0, and bits 7..2 read 1. Any other pointer value returns the flash byte.
- R4: Any load taken while armed clears both enable bits at that edge, whatever the pointer.
- R5: With no load, both bits clear at the edge that falls min(LOAD_WIN, STORE_WIN) edges after arming. A later load returns flash. A store strobe while armed also clears both bits and does not change `loadData`.
- R6: While `eeBusy` is high, register writes are ignored, the armed state is cleared at that edge, and a load at that edge returns the flash byte.
- R7: When not armed, a load returns `flashByte` sampled at the load edge. `loadData` holds its value when there is no load.
- R8: Reset clears both enable bits, the window counter and `loadData`, so that `ctrlReg` reads 0x00 and loads behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| loadStrobe | input | 1 | Program-memory load issued this cycle |
| storeStrobe | input | 1 | Program-memory store issued this cycle |
| zPtr | input | 16 | Byte address pointer of the load |
| eeBusy | input | 1 | EEPROM write in progress |
| flashByte | input | 8 | Flash byte at the pointer address |
| fuseLow | input | 8 | Fuse low byte value |
| lockBits | input | 2 | Lock bits (bit 1 second, bit 0 first) |
| loadData | output | 8 | Registered load result |
| ctrlReg | output | 8 | Control register readback |

## Verification
The embedded properties check the following on every cycle:
- a valid write arms the block;
- an EEPROM-busy cycle always leaves the block disarmed;
- a load or a store taken while armed disarms it;
- `loadData` never moves without a load;
- a lock readback always carries ones in its upper bits.

Only the bench scenarios can show:
- the exact edge where the window expires;
- that an expired window or a blocked write yields the flash byte;
- the address decode on the full 16-bit pointer;
- that reset drops an armed state.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int LOCK_W  = 2;
  localparam int RD_BIT  = 3;
  localparam int PG_BIT  = 0;
  localparam logic [DATA_W-1:0] ARM_VALUE = DATA_W'((1 << RD_BIT) | (1 << PG_BIT));

  typedef struct packed {
    logic captureEn;
    logic useCfg;
    logic pickLock;
  } dpStrobes_t;
endpackage

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
  import cfg_readback_pkg::*;
#(
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               loadStrobe,
  input  logic               storeStrobe,
  input  logic [ADDR_W-1:0]  zPtr,
  input  logic               eeBusy,
  output dpStrobes_t         strobes,
  output logic [DATA_W-1:0]  ctrlReg
);
  localparam int WIN = (LOAD_WIN < STORE_WIN) ? LOAD_WIN : STORE_WIN;
  localparam int CW  = $clog2(WIN + 1);

  logic          armed;
  logic [CW-1:0] ageCnt;
  logic          wrAccepted;
  logic          armHit;
  logic          cfgAddr;
  logic          lastAge;

  assign wrAccepted = regWrEn && !eeBusy;
  assign armHit     = (regWrData == ARM_VALUE);
  assign cfgAddr    = (zPtr[ADDR_W-1:1] == '0);
  assign lastAge    = (ageCnt == CW'(WIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      ageCnt <= '0;
    end else if (wrAccepted) begin
      armed  <= armHit;
      ageCnt <= '0;
    end else if (armed) begin
      if (eeBusy || loadStrobe || storeStrobe || lastAge) begin
        armed  <= 1'b0;
        ageCnt <= '0;
      end else begin
        ageCnt <= ageCnt + CW'(1);
      end
    end
  end

  always_comb begin
    strobes.captureEn = loadStrobe;
    strobes.useCfg    = armed && loadStrobe && !eeBusy && cfgAddr;
    strobes.pickLock  = zPtr[0];
  end

  assign ctrlReg = armed ? ARM_VALUE : '0;

  // R1
  write_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !eeBusy && regWrData == ARM_VALUE) |=> (ctrlReg == ARM_VALUE));

  // R6
  ee_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeBusy |=> (ctrlReg == '0));

  // R4
  use_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg != '0 && loadStrobe && !regWrEn) |=> (ctrlReg == '0));

  // R5
  store_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg != '0 && storeStrobe && !regWrEn) |=> (ctrlReg == '0));
endmodule

// File: rtl/cfg_readback_dp.sv
module cfg_readback_dp
  import cfg_readback_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strobes,
  input  logic [DATA_W-1:0]  flashByte,
  input  logic [DATA_W-1:0]  fuseLow,
  input  logic [LOCK_W-1:0]  lockBits,
  output logic [DATA_W-1:0]  loadData
);
  logic [DATA_W-1:0] lockWord;
  logic [DATA_W-1:0] cfgWord;

  assign lockWord = {{(DATA_W-LOCK_W){1'b1}}, lockBits};
  assign cfgWord  = strobes.pickLock ? lockWord : fuseLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  loadData <= '0;
    else if (strobes.captureEn) loadData <= strobes.useCfg ? cfgWord : flashByte;
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.captureEn |=> $stable(loadData));

  // R3
  lock_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureEn && strobes.useCfg && strobes.pickLock)
      |=> (loadData[DATA_W-1:LOCK_W] == '1));
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_readback_pkg::*;
#(
  parameter int LOAD_WIN  = 3,
  parameter int STORE_WIN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        loadStrobe,
  input  logic        storeStrobe,
  input  logic [15:0] zPtr,
  input  logic        eeBusy,
  input  logic [7:0]  flashByte,
  input  logic [7:0]  fuseLow,
  input  logic [1:0]  lockBits,
  output logic [7:0]  loadData,
  output logic [7:0]  ctrlReg
);
  dpStrobes_t strobes;

  cfg_readback_ctrl #(.LOAD_WIN(LOAD_WIN), .STORE_WIN(STORE_WIN)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .loadStrobe(loadStrobe), .storeStrobe(storeStrobe), .zPtr(zPtr),
    .eeBusy(eeBusy), .strobes(strobes), .ctrlReg(ctrlReg)
  );

  cfg_readback_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .flashByte(flashByte),
    .fuseLow(fuseLow), .lockBits(lockBits), .loadData(loadData)
  );
endmodule

// File: tb/cfg_readback_tb_top.sv
`timescale 1ns/1ps
module cfg_readback_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        loadStrobe = 1'b0;
  logic        storeStrobe = 1'b0;
  logic [15:0] zPtr = '0;
  logic        eeBusy = 1'b0;
  logic [7:0]  flashByte;
  logic [7:0]  fuseLow = 8'h62;
  logic [1:0]  lockBits = 2'b10;
  logic [7:0]  loadData;
  logic [7:0]  ctrlReg;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;
  assign flashByte = zPtr[7:0] ^ 8'hA5;

  cfg_readback dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .loadStrobe(loadStrobe), .storeStrobe(storeStrobe), .zPtr(zPtr),
    .eeBusy(eeBusy), .flashByte(flashByte), .fuseLow(fuseLow),
    .lockBits(lockBits), .loadData(loadData), .ctrlReg(ctrlReg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [7:0] v);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doLoad(input logic [15:0] a, input logic [7:0] exp, input string req);
    expQ.push_back(exp); tagQ.push_back(req);
    loadStrobe = 1'b1; zPtr = a;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic hit;
      @(posedge clk);
      hit = loadStrobe;
      @(negedge clk);
      if (hit) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected load result actual=%02h expected=none", loadData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t, loadData, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk("R8 reset ctrl", ctrlReg, 8'h00);
    chk("R8 reset data", loadData, 8'h00);

    doLoad(16'h0000, 8'hA5, "R7 unarmed load");
    idle(2);
    chk("R7 hold", loadData, 8'hA5);

    writeCtrl(8'h09);
    chk("R1 armed", ctrlReg, 8'h09);
    doLoad(16'h0001, 8'hFE, "R3 lock read");
    chk("R4 used", ctrlReg, 8'h00);

    writeCtrl(8'h09);
    idle(2);
    chk("R2 still armed", ctrlReg, 8'h09);
    doLoad(16'h0000, 8'h62, "R2 last window edge fuse");

    writeCtrl(8'h09);
    idle(3);
    chk("R5 timeout", ctrlReg, 8'h00);
    doLoad(16'h0000, 8'hA5, "R5 flash after timeout");

    writeCtrl(8'h08);
    chk("R1 one bit", ctrlReg, 8'h00);
    writeCtrl(8'h0B);
    chk("R1 extra bit", ctrlReg, 8'h00);
    doLoad(16'h0001, 8'hA4, "R1 unarmed flash");

    eeBusy = 1'b1;
    writeCtrl(8'h09);
    eeBusy = 1'b0;
    chk("R6 write blocked", ctrlReg, 8'h00);

    writeCtrl(8'h09);
    eeBusy = 1'b1;
    doLoad(16'h0000, 8'hA5, "R6 busy load flash");
    eeBusy = 1'b0;
    chk("R6 disarmed", ctrlReg, 8'h00);

    writeCtrl(8'h09);
    storeStrobe = 1'b1;
    idle(1);
    storeStrobe = 1'b0;
    chk("R5 store clears", ctrlReg, 8'h00);
    chk("R5 store no data change", loadData, 8'hA5);
    doLoad(16'h0000, 8'hA5, "R5 flash after store");

    writeCtrl(8'h09);
    doLoad(16'h0101, 8'hA4, "R3 other address flash");
    chk("R4 other address used", ctrlReg, 8'h00);

    lockBits = 2'b01;
    writeCtrl(8'h09);
    idle(1);
    doLoad(16'h0001, 8'hFD, "R3 lock order");

    writeCtrl(8'h09);
    writeCtrl(8'h00);
    chk("R1 clear by write", ctrlReg, 8'h00);

    writeCtrl(8'h09);
    rstN = 1'b0;
    #1;
    chk("R8 reset armed", ctrlReg, 8'h00);
    chk("R8 reset data clr", loadData, 8'h00);
    idle(1);
    rstN = 1'b1;
    doLoad(16'h0000, 8'hA5, "R8 normal after reset");

    idle(3);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 missing results actual=%0d expected=0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule